// File: doc/BRIEF.md
# Voice Group Block Sequencer

This block plays one voice group out of a sample memory that holds fixed-size voice blocks. A group is not one contiguous address range. It is an ordered list of block numbers kept in an entry table, and several groups can reuse the same block and join blocks from different recordings in any order. After a start pulse that carries a group number, the sequencer looks up where that group's list begins. It then walks the list entry by entry and reads each named block byte by byte. Each sample tick, it presents one sample.

Two synchronous memories sit outside the block, and both have one cycle of read latency. The table memory holds two regions. The lower words give each group's start index. The upper words hold the list entries. The sample memory holds the voice bytes. A configuration input selects the sample format. In 8-bit PCM each byte is one sample. In 4-bit ADPCM each byte holds two codes, which go unchanged to an external decoder. A stop request ends playback cleanly at the next tick.

Top module: `voice_seq`

## Requirements
- R1: After reset, `busy` and `smp_valid` are low and stay low until a group is started.
- R2: A `start` pulse while idle raises `busy` on the next cycle, and the block reads table word `grp`.
- R3: The low 10 bits of group word g give the start index s. Entry s sits at table word GROUPS+s. In an entry word, bit 8 is the last-entry flag and bits 7:0 are the block number b. The byte read from block b at offset o uses sample-memory address b*512+o.
- R4: In PCM mode (`adpcm`=0), each accepted tick emits the next byte as an 8-bit sample. Bytes go in ascending offset order from 0 to 511 within each block.
- R5: In ADPCM mode, each byte gives two samples. Bits 3:0 come first and bits 7:4 come second, each on `smp_data[3:0]` with `smp_data[7:4]` zero.
- R6: After the last sample of a block, playback moves on to the next table entry. After the last sample of an entry flagged last, `busy` falls in the same cycle that this sample's `smp_valid` rises.
- R7: A `stop` request during playback makes the next tick (or the same-cycle tick) emit nothing and drop `busy`.
- R8: A `start` pulse while busy is ignored, and the playing group continues unchanged.
- R9: `smp_valid` is a one-cycle strobe in the cycle after an accepted tick. Ticks while idle produce nothing. Ticks must be at least 6 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled with `grp` |
| grp | input | 5 | Group number to play |
| stop | input | 1 | Stop request |
| tick | input | 1 | Sample-rate tick |
| adpcm | input | 1 | Format select: 1 = 4-bit ADPCM codes, 0 = 8-bit PCM |
| tbl_addr | output | 10 | Table memory read address |
| tbl_rdata | input | 10 | Table memory read data, one cycle after address |
| mem_addr | output | 17 | Sample memory byte address |
| mem_rdata | input | 8 | Sample memory read data, one cycle after address |
| smp_valid | output | 1 | Sample strobe |
| smp_data | output | 8 | Sample byte or 4-bit code |
| busy | output | 1 | Group playback in progress |

## Verification
A one-entry PCM group checks the byte order within a block. A two-entry ADPCM group checks nibble order and the jump between blocks. Two groups share a block, which separates a true table lookup from a shortcut based on the group number. The highest group uses the top entry of the table, which exposes errors in index width and region offset. A stop pulse in the middle of a group and a second start during playback check that the end of playback is clean and that the playing group is not disturbed.

// File: rtl/voice_seq_pkg.sv
package voice_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_GADR  = 3'd1,
    S_GDAT  = 3'd2,
    S_EADR  = 3'd3,
    S_EDAT  = 3'd4,
    S_BADR  = 3'd5,
    S_BDAT  = 3'd6,
    S_READY = 3'd7
  } seq_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/voice_seq_ctrl.sv
module voice_seq_ctrl
  import voice_seq_pkg::*;
#(
  parameter int GRP_W = 5,
  parameter int ENT_W = 10,
  parameter int BLK_W = 8,
  parameter int OFF_W = 9,
  parameter int TBL_DW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic              tick,
  input  logic              adpcm,
  input  logic [TBL_DW-1:0] tbl_rdata,
  output logic              ld_grp,
  output logic              ld_ent,
  output logic [ENT_W-1:0]  ent_idx,
  output logic              ld_byte,
  output logic [BLK_W-1:0]  byte_blk,
  output logic [OFF_W-1:0]  byte_off,
  output logic              cap_byte,
  output logic              emit,
  output logic              emit_hi,
  output logic              busy
);
  localparam logic [OFF_W-1:0] OFF_LAST = {OFF_W{1'b1}};

  seq_state_t       state_q;
  logic [ENT_W-1:0] ent_q;
  logic [OFF_W-1:0] off_q;
  logic [BLK_W-1:0] blk_q;
  logic             last_q;
  logic             half_q;
  logic             stop_q;
  logic             halt;

  assign busy = (state_q != S_IDLE);
  assign halt = busy && tick && (stop || stop_q);

  always_comb begin
    ld_grp   = 1'b0;
    ld_ent   = 1'b0;
    ent_idx  = ent_q + 1'b1;
    ld_byte  = 1'b0;
    byte_blk = blk_q;
    byte_off = off_q + 1'b1;
    cap_byte = (state_q == S_BDAT);
    emit     = 1'b0;
    emit_hi  = half_q;
    if (state_q == S_IDLE && start) ld_grp = 1'b1;
    if (!halt) begin
      case (state_q)
        S_GDAT: begin
          ld_ent  = 1'b1;
          ent_idx = tbl_rdata[ENT_W-1:0];
        end
        S_EDAT: begin
          ld_byte  = 1'b1;
          byte_blk = tbl_rdata[BLK_W-1:0];
          byte_off = '0;
        end
        S_READY: if (tick) begin
          emit = 1'b1;
          if (!(adpcm && !half_q)) begin
            if (off_q != OFF_LAST) ld_byte = 1'b1;
            else if (!last_q)      ld_ent  = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      ent_q   <= '0;
      off_q   <= '0;
      blk_q   <= '0;
      last_q  <= 1'b0;
      half_q  <= 1'b0;
      stop_q  <= 1'b0;
    end else if (halt) begin
      state_q <= S_IDLE;
      stop_q  <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      if (busy && stop) stop_q <= 1'b1;
      if (ld_ent) ent_q <= ent_idx;
      if (ld_byte) begin
        blk_q <= byte_blk;
        off_q <= byte_off;
      end
      case (state_q)
        S_IDLE: if (start) begin
          state_q <= S_GADR;
          stop_q  <= 1'b0;
          half_q  <= 1'b0;
        end
        S_GADR: state_q <= S_GDAT;
        S_GDAT: state_q <= S_EADR;
        S_EADR: state_q <= S_EDAT;
        S_EDAT: begin
          last_q  <= tbl_rdata[BLK_W];
          state_q <= S_BADR;
        end
        S_BADR: state_q <= S_BDAT;
        S_BDAT: state_q <= S_READY;
        S_READY: if (tick) begin
          if (adpcm && !half_q) half_q <= 1'b1;
          else begin
            half_q <= 1'b0;
            if (off_q != OFF_LAST) state_q <= S_BADR;
            else if (!last_q)      state_q <= S_EADR;
            else                   state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R2: playback only begins from a start request
  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R7: a pending stop and a tick end playback
  a_r7_stop_ends: assert property (@(posedge clk) disable iff (rst)
    (busy && tick && (stop || stop_q)) |=> !busy);

  // R8: a start while busy does not end playback
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !tick && !stop && !stop_q) |=> busy);
endmodule

// File: rtl/voice_seq_addr.sv
module voice_seq_addr #(
  parameter int GROUPS = 32,
  parameter int GRP_W  = 5,
  parameter int ENT_W  = 10,
  parameter int BLK_W  = 8,
  parameter int OFF_W  = 9,
  parameter int TBL_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_grp,
  input  logic [GRP_W-1:0]  grp,
  input  logic              ld_ent,
  input  logic [ENT_W-1:0]  ent_idx,
  input  logic              ld_byte,
  input  logic [BLK_W-1:0]  byte_blk,
  input  logic [OFF_W-1:0]  byte_off,
  output logic [TBL_AW-1:0] tbl_addr,
  output logic [BLK_W+OFF_W-1:0] mem_addr
);
  localparam logic [TBL_AW-1:0] ENT_BASE = TBL_AW'(GROUPS);

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_addr <= '0;
      mem_addr <= '0;
    end else begin
      if (ld_grp)      tbl_addr <= TBL_AW'(grp);
      else if (ld_ent) tbl_addr <= ENT_BASE + TBL_AW'(ent_idx);
      if (ld_byte)     mem_addr <= {byte_blk, byte_off};
    end
  end

  // R3: the entry region lies above the group region
  a_r3_entry_region: assert property (@(posedge clk) disable iff (rst)
    $past(ld_ent) |-> (tbl_addr >= ENT_BASE));
endmodule

// File: rtl/voice_seq_out.sv
module voice_seq_out (
  input  logic       clk,
  input  logic       rst,
  input  logic       cap_byte,
  input  logic [7:0] mem_rdata,
  input  logic       emit,
  input  logic       emit_hi,
  input  logic       adpcm,
  output logic       smp_valid,
  output logic [7:0] smp_data
);
  logic [7:0] byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q    <= '0;
      smp_valid <= 1'b0;
      smp_data  <= '0;
    end else begin
      if (cap_byte) byte_q <= mem_rdata;
      smp_valid <= emit;
      if (emit) begin
        if (!adpcm)       smp_data <= byte_q;
        else if (emit_hi) smp_data <= {4'd0, byte_q[7:4]};
        else              smp_data <= {4'd0, byte_q[3:0]};
      end
    end
  end

  // R4: the emitted byte is the captured one, never one arriving mid-emit
  a_r4_byte_held: assert property (@(posedge clk) disable iff (rst)
    emit |-> !cap_byte);
endmodule

// File: rtl/voice_seq.sv
module voice_seq
  import voice_seq_pkg::*;
#(
  parameter int GROUPS      = 32,
  parameter int ENTRIES     = 960,
  parameter int BLOCKS      = 252,
  parameter int BLOCK_BYTES = 512,
  localparam int GRP_W  = $clog2(GROUPS),
  localparam int ENT_W  = $clog2(ENTRIES),
  localparam int BLK_W  = $clog2(BLOCKS),
  localparam int OFF_W  = $clog2(BLOCK_BYTES),
  localparam int TBL_AW = $clog2(GROUPS + ENTRIES),
  localparam int TBL_DW = imax(ENT_W, BLK_W + 1),
  localparam int MEM_AW = BLK_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [GRP_W-1:0]  grp,
  input  logic              stop,
  input  logic              tick,
  input  logic              adpcm,
  output logic [TBL_AW-1:0] tbl_addr,
  input  logic [TBL_DW-1:0] tbl_rdata,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              smp_valid,
  output logic [7:0]        smp_data,
  output logic              busy
);
  logic             ld_grp, ld_ent, ld_byte, cap_byte, emit, emit_hi;
  logic [ENT_W-1:0] ent_idx;
  logic [BLK_W-1:0] byte_blk;
  logic [OFF_W-1:0] byte_off;

  voice_seq_ctrl #(
    .GRP_W(GRP_W), .ENT_W(ENT_W), .BLK_W(BLK_W), .OFF_W(OFF_W), .TBL_DW(TBL_DW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .tick(tick), .adpcm(adpcm),
    .tbl_rdata(tbl_rdata), .ld_grp(ld_grp), .ld_ent(ld_ent), .ent_idx(ent_idx),
    .ld_byte(ld_byte), .byte_blk(byte_blk), .byte_off(byte_off),
    .cap_byte(cap_byte), .emit(emit), .emit_hi(emit_hi), .busy(busy)
  );

  voice_seq_addr #(
    .GROUPS(GROUPS), .GRP_W(GRP_W), .ENT_W(ENT_W), .BLK_W(BLK_W),
    .OFF_W(OFF_W), .TBL_AW(TBL_AW)
  ) u_addr (
    .clk(clk), .rst(rst), .ld_grp(ld_grp), .grp(grp), .ld_ent(ld_ent),
    .ent_idx(ent_idx), .ld_byte(ld_byte), .byte_blk(byte_blk),
    .byte_off(byte_off), .tbl_addr(tbl_addr), .mem_addr(mem_addr)
  );

  voice_seq_out u_out (
    .clk(clk), .rst(rst), .cap_byte(cap_byte), .mem_rdata(mem_rdata),
    .emit(emit), .emit_hi(emit_hi), .adpcm(adpcm),
    .smp_valid(smp_valid), .smp_data(smp_data)
  );

  // R9: every strobe answers a tick one cycle earlier
  a_r9_valid_after_tick: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> $past(tick));

  // R6: samples only come from a playing group
  a_r6_valid_needs_busy: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> $past(busy));

  // R1: an idle block stays quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> !smp_valid);
endmodule

// File: tb/voice_seq_test.sv
module voice_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, stop = 1'b0, adpcm = 1'b0, tick;
  logic [4:0]  grp = '0;
  logic [9:0]  tbl_addr, tbl_rdata;
  logic [16:0] mem_addr;
  logic [7:0]  mem_rdata, smp_data;
  logic        smp_valid, busy;

  int checks = 0, fails = 0, cyc = 0, tcnt = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  voice_seq uut (
    .clk(clk), .rst(rst), .start(start), .grp(grp), .stop(stop), .tick(tick),
    .adpcm(adpcm), .tbl_addr(tbl_addr), .tbl_rdata(tbl_rdata),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .smp_valid(smp_valid),
    .smp_data(smp_data), .busy(busy)
  );

  // table content: group g starts at 3g (group 31 at 958), has (g%3)+1 entries
  function automatic int g_start(int g);
    return (g == 31) ? 958 : g * 3;
  endfunction
  function automatic int g_len(int g);
    return (g % 3) + 1;
  endfunction
  function automatic int g_blk(int g, int j);
    return ((g % 4) * 60 + j * 100) % 252;
  endfunction
  function automatic logic [9:0] tbl_word(int a);
    if (a < 32) return 10'(g_start(a));
    for (int g = 0; g < 32; g++)
      for (int j = 0; j < g_len(g); j++)
        if (a - 32 == g_start(g) + j)
          return {1'b0, (j == g_len(g) - 1), 8'(g_blk(g, j))};
    return 10'h0FF;
  endfunction
  function automatic logic [7:0] byte_at(int a);
    return 8'(a * 13 + (a >> 9) * 71 + 5);
  endfunction

  always @(posedge clk) begin
    tbl_rdata <= tbl_word(int'(tbl_addr));
    mem_rdata <= byte_at(int'(mem_addr));
  end

  // free-running tick every 8 cycles
  always @(posedge clk) tcnt <= (tcnt + 1) % 8;
  assign tick = (tcnt == 0);

  // reference model
  logic [7:0] q[$];
  bit m_busy = 0, m_pend = 0, e_valid = 0;
  logic [7:0] e_data = '0;
  always @(posedge clk) begin
    e_valid = 0;
    if (rst) begin
      m_busy = 0; m_pend = 0; q.delete();
    end else if (!m_busy) begin
      if (start) begin
        m_busy = 1; m_pend = 0; q.delete();
        for (int j = 0; j < g_len(grp); j++)
          for (int o = 0; o < 512; o++) begin
            logic [7:0] b;
            b = byte_at(g_blk(grp, j) * 512 + o);
            if (adpcm) begin
              q.push_back({4'd0, b[3:0]});
              q.push_back({4'd0, b[7:4]});
            end else q.push_back(b);
          end
      end
    end else begin
      if (stop) m_pend = 1;
      if (tick) begin
        if (m_pend) m_busy = 0;
        else begin
          e_valid = 1;
          e_data = q.pop_front();
          if (q.size() == 0) m_busy = 0;
        end
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      check(m_busy ? tag : "R1", 32'(busy), 32'(m_busy), "busy");
      check((m_busy || e_valid) ? tag : "R9", 32'(smp_valid), 32'(e_valid), "smp_valid");
      if (e_valid) check(tag, 32'(smp_data), 32'(e_data), "smp_data");
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // start aligned so its edge is the one right after a tick edge
  task automatic play(int g, bit mode);
    @(negedge clk);
    while (tcnt != 1) @(negedge clk);
    grp = 5'(g); adpcm = mode; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", 32'(busy), 32'd1, "busy after start");
    check("R2", 32'(tbl_addr), 32'(g), "group table address");
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1", 32'(busy), 32'd0, "busy in reset");
    check("R1", 32'(smp_valid), 32'd0, "valid in reset");
    rst = 1'b0;
    repeat (30) @(negedge clk);
    check("R1", 32'(busy), 32'd0, "busy idle after reset");
    tag = "R4"; play(0, 1'b0); wait_idle();
    tag = "R5"; play(4, 1'b1); wait_idle();
    tag = "R3"; play(31, 1'b0); wait_idle();
    check("R6", 32'(busy), 32'd0, "idle after last entry");
    tag = "R8"; play(2, 1'b0);
    repeat (200) @(negedge clk);
    grp = 5'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    tag = "R7"; play(1, 1'b1);
    repeat (300) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    repeat (12) @(negedge clk);
    check("R7", 32'(busy), 32'd0, "busy after stop");
    tag = "R6"; play(5, 1'b0);
    repeat (100) @(negedge clk);
    while (tcnt != 0) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check("R7", 32'(busy), 32'd0, "stop with same-cycle tick");
    wait_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule